// File: doc/BRIEF.md
# Shifter Operand Generator

This block builds the second source operand of a 32-bit data-processing instruction from the instruction word, the value already read from the register named as the shifted source, the value of the register that can supply a shift count, and the current carry flag. It produces the 32-bit operand and a carry-out. The carry-out is the last bit that leaves the word during the shift or rotation, and the flag logic uses it for logical instructions that set flags.

Bits 25 and 4 of the word select one of three forms. The first is an 8-bit constant rotated right by an even amount. The second shifts the register value by a 5-bit count held in the word. The third shifts it by the low byte of the second register value. In the immediate-count form, a count of zero has a special meaning for every shift type except left shift. The logic is purely combinational. A parameter can add a register stage on the two outputs.

Top module: `opnd_shifter`

## Requirements
- R1: When instr[25]=1, the operand is instr[7:0], zero-extended and rotated right by twice instr[11:8].
- R2: In the constant form the carry-out equals c_in when instr[11:8]=0. Otherwise it equals bit 31 of the rotated operand.
- R3: When instr[25]=0 and instr[4]=0, rm_val is shifted by instr[11:7]. The type in instr[6:5] is 00 left, 01 logical right, 10 arithmetic right, 11 rotate right, and the carry-out is the last bit shifted out.
- R4: In the constant-count form, a left shift by 0 returns rm_val unchanged with carry-out c_in.
- R5: In the constant-count form, a logical or arithmetic right shift with count 0 acts as a shift by 32. Logical gives 0 and arithmetic gives 32 copies of rm_val[31]. Both give carry-out rm_val[31].
- R6: In the constant-count form, a rotate with count 0 is a one-bit rotate through carry. The result is {c_in, rm_val[31:1]} and the carry-out is rm_val[0].
- R7: When instr[25]=0 and instr[4]=1, the count is rs_val[7:0] and rs_val[31:8] is ignored. A count of 0 returns rm_val with carry-out c_in.
- R8: For a register count, a left or logical right shift by exactly 32 gives 0 with carry-out rm_val[0] (left) or rm_val[31] (right). A count above 32 gives 0 with carry-out 0.
- R9: For a register count, an arithmetic shift by 32 or more gives 32 copies of rm_val[31] and carry-out rm_val[31]. A rotate by a nonzero multiple of 32 returns rm_val with carry-out rm_val[31]. Any other rotate uses the count modulo 32.
- R10: With REG_OUT=1, opnd and c_out present the result of the inputs seen at the previous rising clock edge, and reset clears them to 0. With REG_OUT=0, they follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Data-processing instruction word |
| rm_val | input | 32 | Value of the register being shifted |
| rs_val | input | 32 | Value of the register supplying a shift count |
| c_in | input | 1 | Current carry flag |
| opnd | output | 32 | Shifted or rotated operand |
| c_out | output | 1 | Shifter carry-out |

## Verification
The incoming carry flag can act as data and as the carry-out in the same cycle. In the one-bit rotate through carry, c_in becomes bit 31 while rm_val[0] leaves as the carry. In the other zero-count cases, c_in passes straight to the carry-out. The bench drives back-to-back vectors in which c_in toggles while the count field stays zero. It judges each registered result against a bit-serial bench model: the operand and the carry must both match the vector captured one edge earlier, with no leakage from the neighbouring vector.

// File: rtl/opg_pkg.sv
package opg_pkg;
   localparam int WORD_W   = 32;
   localparam int IMM_W    = 8;
   localparam int ROT_W    = 4;
   localparam int SAMT_W   = 5;
   localparam int RAMT_W   = 8;

   // instruction field positions (decoded by this block)
   localparam int POS_IFORM = 25;
   localparam int POS_RFORM = 4;
   localparam int POS_ROT   = 8;
   localparam int POS_SAMT  = 7;
   localparam int POS_KIND  = 5;

   typedef enum logic [1:0] {
      SH_LSL = 2'b00,
      SH_LSR = 2'b01,
      SH_ASR = 2'b10,
      SH_ROR = 2'b11
   } shift_kind_e;
endpackage

// File: rtl/opg_imm_rot.sv
module opg_imm_rot #(
   parameter int WORD_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4
) (
   input  logic [IMM_W-1:0]  imm,
   input  logic [ROT_W-1:0]  rot,
   input  logic              c_in,
   output logic [WORD_W-1:0] val,
   output logic              c_out
);
   localparam int AMT_W = ROT_W + 1;

   if (IMM_W > WORD_W) begin : g_bad_imm
      $error("opg_imm_rot: IMM_W must not exceed WORD_W");
   end
   if (2 * ((1 << ROT_W) - 1) >= WORD_W) begin : g_bad_rot
      $error("opg_imm_rot: rotate range exceeds word");
   end

   logic [WORD_W-1:0] ext;
   logic [AMT_W-1:0]  amt;

   always_comb begin
      ext = WORD_W'(imm);
      amt = {rot, 1'b0};
      if (amt == '0) begin
         val   = ext;
         c_out = c_in;
      end else begin
         val   = (ext >> amt) | (ext << (WORD_W - int'(amt)));
         c_out = val[WORD_W-1];
      end
   end
endmodule

// File: rtl/opg_barrel.sv
module opg_barrel
   import opg_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [WORD_W-1:0] val,
   input  logic              c_in,
   input  shift_kind_e       kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              rrx,
   output logic [WORD_W-1:0] res,
   output logic              c_out
);
   localparam int LG = $clog2(WORD_W);

   if ((1 << LG) != WORD_W) begin : g_bad_word
      $error("opg_barrel: WORD_W must be a power of two");
   end
   if ((1 << AMT_W) <= WORD_W) begin : g_bad_amt
      $error("opg_barrel: AMT_W too narrow to express a full-word shift");
   end

   logic                big;
   logic [LG:0]         sh;
   logic [LG-1:0]       rmod;
   logic [WORD_W:0]     wide;
   logic signed [WORD_W:0] swide;

   always_comb begin
      big   = amt > AMT_W'(WORD_W);
      sh    = big ? (LG+1)'(WORD_W) : amt[LG:0];
      rmod  = amt[LG-1:0];
      wide  = '0;
      swide = '0;
      res   = val;
      c_out = c_in;
      if (rrx) begin
         res   = {c_in, val[WORD_W-1:1]};
         c_out = val[0];
      end else if (amt != '0) begin
         unique case (kind)
            SH_LSL: begin
               wide = {1'b0, val} << sh;
               res  = big ? '0 : wide[WORD_W-1:0];
               c_out = big ? 1'b0 : wide[WORD_W];
            end
            SH_LSR: begin
               wide = {val, 1'b0} >> sh;
               res  = big ? '0 : wide[WORD_W:1];
               c_out = big ? 1'b0 : wide[0];
            end
            SH_ASR: begin
               swide = $signed({val, 1'b0}) >>> sh;
               res   = swide[WORD_W:1];
               c_out = swide[0];
            end
            SH_ROR: begin
               if (rmod == '0) begin
                  res   = val;
                  c_out = val[WORD_W-1];
               end else begin
                  res   = (val >> rmod) | (val << ((LG+1)'(WORD_W) - {1'b0, rmod}));
                  c_out = res[WORD_W-1];
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
   import opg_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       instr,
   input  logic [31:0]       rm_val,
   input  logic [31:0]       rs_val,
   input  logic              c_in,
   output logic [31:0]       opnd,
   output logic              c_out
);
   if (WORD_W != 32) begin : g_bad_word
      $error("opnd_shifter: encoding is fixed to a 32-bit word");
   end

   logic              imm_form, by_reg, b_rrx;
   shift_kind_e       kind;
   logic [SAMT_W-1:0] imm_amt;
   logic [RAMT_W-1:0] b_amt;
   logic [WORD_W-1:0] rot_val, bar_val, comb_val;
   logic              rot_c, bar_c, comb_c;
   logic              unused_bits;

   assign imm_form    = instr[POS_IFORM];
   assign by_reg      = instr[POS_RFORM];
   assign kind        = shift_kind_e'(instr[POS_KIND +: 2]);
   assign imm_amt     = instr[POS_SAMT +: SAMT_W];
   assign unused_bits = ^{instr[31:26], instr[24:12], rs_val[WORD_W-1:RAMT_W]};

   always_comb begin
      b_rrx = 1'b0;
      if (by_reg) begin
         b_amt = rs_val[RAMT_W-1:0];
      end else if (imm_amt == '0 && (kind == SH_LSR || kind == SH_ASR)) begin
         b_amt = RAMT_W'(WORD_W);
      end else begin
         b_amt = RAMT_W'(imm_amt);
         b_rrx = (imm_amt == '0) && (kind == SH_ROR);
      end
   end

   opg_imm_rot #(.WORD_W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
      .imm   (instr[IMM_W-1:0]),
      .rot   (instr[POS_ROT +: ROT_W]),
      .c_in  (c_in),
      .val   (rot_val),
      .c_out (rot_c)
   );

   opg_barrel #(.WORD_W(WORD_W), .AMT_W(RAMT_W)) u_bar (
      .val   (rm_val),
      .c_in  (c_in),
      .kind  (kind),
      .amt   (b_amt),
      .rrx   (b_rrx),
      .res   (bar_val),
      .c_out (bar_c)
   );

   assign comb_val = imm_form ? rot_val : bar_val;
   assign comb_c   = imm_form ? rot_c   : bar_c;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            opnd  <= '0;
            c_out <= 1'b0;
         end else begin
            opnd  <= comb_val;
            c_out <= comb_c;
         end
      end
      // R10
      reg_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (opnd == $past(comb_val) && c_out == $past(comb_c)));
   end else begin : g_comb
      assign opnd  = comb_val;
      assign c_out = comb_c;
   end

   // R1
   imm_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      imm_form |-> $countones(comb_val) == $countones(instr[IMM_W-1:0]));
   // R2
   imm_rot0_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (imm_form && instr[POS_ROT +: ROT_W] == '0) |-> comb_c == c_in);
   // R4
   lsl0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!imm_form && !by_reg && kind == SH_LSL && imm_amt == '0)
         |-> (comb_val == rm_val && comb_c == c_in));
   // R6
   rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!imm_form && !by_reg && kind == SH_ROR && imm_amt == '0)
         |-> (comb_val[WORD_W-2:0] == rm_val[WORD_W-1:1] && comb_val[WORD_W-1] == c_in
              && comb_c == rm_val[0]));
   // R7
   reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!imm_form && by_reg && rs_val[RAMT_W-1:0] == '0)
         |-> (comb_val == rm_val && comb_c == c_in));
   // R8
   reg_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!imm_form && by_reg && rs_val[RAMT_W-1:0] > RAMT_W'(WORD_W)
       && (kind == SH_LSL || kind == SH_LSR)) |-> (comb_val == '0 && !comb_c));
endmodule

// File: tb/test_opnd_shifter.sv
`timescale 1ns/1ps
module test_opnd_shifter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0, rm_val = '0, rs_val = '0;
   logic        c_in = 1'b0;
   logic [31:0] opnd;
   logic        c_out;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   opnd_shifter #(.REG_OUT(1'b1)) i_opnd_shifter (
      .clk(clk), .rst_n(rst_n), .instr(instr), .rm_val(rm_val),
      .rs_val(rs_val), .c_in(c_in), .opnd(opnd), .c_out(c_out));

   function automatic logic [31:0] f_imm(int rot, int imm8);
      return 32'h0200_0000 | (32'(rot & 15) << 8) | 32'(imm8 & 255);
   endfunction
   function automatic logic [31:0] f_ish(int amt5, int kind);
      return (32'(amt5 & 31) << 7) | (32'(kind & 3) << 5);
   endfunction
   function automatic logic [31:0] f_rsh(int kind);
      return (32'(kind & 3) << 5) | 32'h10;
   endfunction

   // bit-serial reference: returns {carry, value}
   function automatic logic [32:0] model(logic [31:0] ins, logic [31:0] rm,
                                         logic [31:0] rs, logic c);
      logic [31:0] v;
      logic        co;
      int          n;
      int          k;
      co = c;
      if (ins[25]) begin
         v = {24'd0, ins[7:0]};
         for (int i = 0; i < 2 * int'(ins[11:8]); i++) v = {v[0], v[31:1]};
         if (ins[11:8] != 0) co = v[31];
         return {co, v};
      end
      v = rm;
      k = int'(ins[6:5]);
      if (!ins[4]) begin
         n = int'(ins[11:7]);
         if (n == 0) begin
            if (k == 0) return {c, rm};
            if (k == 3) return {rm[0], c, rm[31:1]};
            n = 32;
         end
      end else begin
         n = int'(rs[7:0]);
      end
      for (int i = 0; i < n; i++) begin
         case (k)
            0: begin co = v[31]; v = v << 1; end
            1: begin co = v[0];  v = v >> 1; end
            2: begin co = v[0];  v = {v[31], v[31:1]}; end
            default: begin co = v[0]; v = {v[0], v[31:1]}; end
         endcase
      end
      return {co, v};
   endfunction

   function automatic string req_of(logic [31:0] ins, logic [31:0] rs);
      if (ins[25]) return "R1/R2";
      if (!ins[4]) begin
         if (ins[11:7] != 0) return "R3";
         case (ins[6:5])
            2'b00: return "R4";
            2'b11: return "R6";
            default: return "R5";
         endcase
      end
      if (rs[7:0] == 0) return "R7";
      if (rs[7:0] >= 32) return (ins[6:5] == 2'b00 || ins[6:5] == 2'b01) ? "R8" : "R9";
      return "R9";
   endfunction

   task automatic check(string req, logic [31:0] exp_v, logic exp_c);
      checks++;
      if (opnd !== exp_v || c_out !== exp_c) begin
         fails++;
         $display("FAIL %s actual=%h/%b expected=%h/%b", req, opnd, c_out, exp_v, exp_c);
      end
   endtask

   // drive at negedge, result registered at posedge, sampled at next negedge (R10)
   task automatic run(logic [31:0] ins, logic [31:0] rm, logic [31:0] rs, logic c,
                      string req, logic [31:0] exp_v, logic exp_c);
      instr = ins; rm_val = rm; rs_val = rs; c_in = c;
      @(negedge clk);
      check(req, exp_v, exp_c);
   endtask

   task automatic run_model(logic [31:0] ins, logic [31:0] rm, logic [31:0] rs, logic c);
      logic [32:0] e;
      e = model(ins, rm, rs, c);
      run(ins, rm, rs, c, req_of(ins, rs), e[31:0], e[32]);
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      instr = f_imm(1, 1); c_in = 1'b1;
      @(negedge clk);
      check("R10 reset", 32'h0, 1'b0);
      rst_n = 1'b1;

      // R1 / R2 constant form
      run(f_imm(1, 1),    0, 0, 1'b1, "R1", 32'h4000_0000, 1'b0);
      run(f_imm(4'hA, 1), 0, 0, 1'b1, "R1", 32'h0000_1000, 1'b0);
      run(f_imm(0, 8'h96), 0, 0, 1'b1, "R2", 32'h0000_0096, 1'b1);
      run(f_imm(1, 8'h03), 0, 0, 1'b0, "R2", 32'hC000_0000, 1'b1);
      // R3 constant count
      run(f_ish(31, 1), 32'h8000_0000, 0, 1'b0, "R3", 32'h1, 1'b0);
      run(f_ish(31, 2), 32'h8000_0000, 0, 1'b0, "R3", 32'hFFFF_FFFF, 1'b0);
      run(f_ish(31, 3), 32'h1, 0, 1'b0, "R3", 32'h2, 1'b0);
      // R4
      run(f_ish(0, 0), 32'hDEAD_BEEF, 0, 1'b1, "R4", 32'hDEAD_BEEF, 1'b1);
      // R5
      run(f_ish(0, 1), 32'h8000_0001, 0, 1'b0, "R5", 32'h0, 1'b1);
      run(f_ish(0, 2), 32'h8000_0000, 0, 1'b0, "R5", 32'hFFFF_FFFF, 1'b1);
      run(f_ish(0, 2), 32'h7FFF_FFFF, 0, 1'b1, "R5", 32'h0, 1'b0);
      // R6: back-to-back with toggling carry
      run(f_ish(0, 3), 32'h0, 0, 1'b1, "R6", 32'h8000_0000, 1'b0);
      run(f_ish(0, 3), 32'h1, 0, 1'b0, "R6", 32'h0, 1'b1);
      run(f_ish(0, 3), 32'h8000_0000, 0, 1'b0, "R6", 32'h4000_0000, 1'b0);
      // R7
      run(f_rsh(0), 32'h1, 32'h2, 1'b0, "R7", 32'h4, 1'b0);
      run(f_rsh(1), 32'h2, 32'h1, 1'b0, "R7", 32'h1, 1'b0);
      run(f_rsh(2), 32'h1234_5678, 32'hFFFF_FF00, 1'b1, "R7", 32'h1234_5678, 1'b1);
      // R8
      run(f_rsh(0), 32'h3, 32'd32, 1'b0, "R8", 32'h0, 1'b1);
      run(f_rsh(1), 32'h8000_0000, 32'd32, 1'b0, "R8", 32'h0, 1'b1);
      run(f_rsh(0), 32'hFFFF_FFFF, 32'd40, 1'b1, "R8", 32'h0, 1'b0);
      run(f_rsh(1), 32'hFFFF_FFFF, 32'd255, 1'b1, "R8", 32'h0, 1'b0);
      // R9
      run(f_rsh(3), 32'h1, 32'h1, 1'b0, "R9", 32'h8000_0000, 1'b1);
      run(f_rsh(2), 32'h8000_0000, 32'd200, 1'b0, "R9", 32'hFFFF_FFFF, 1'b1);
      run(f_rsh(3), 32'h8000_0001, 32'd64, 1'b0, "R9", 32'h8000_0001, 1'b1);
      run(f_rsh(3), 32'h0000_0010, 32'd36, 1'b1, "R9", 32'h1, 1'b0);

      // constrained random
      for (int i = 0; i < 600; i++) begin
         logic [31:0] ins, rm, rs;
         int sel;
         sel = int'($urandom % 3);
         rm  = $urandom;
         rs  = $urandom;
         if (($urandom % 4) != 0) rs[7:0] = 8'($urandom % 70);
         case (sel)
            0: ins = f_imm(int'($urandom), int'($urandom));
            1: ins = f_ish((($urandom % 4) == 0) ? 0 : int'($urandom), int'($urandom));
            default: ins = f_rsh(int'($urandom));
         endcase
         ins = ins | ({6'($urandom), 1'b0, 13'($urandom), 12'd0} & 32'hFC0F_F000);
         run_model(ins, rm, rs, 1'($urandom));
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule